// File: doc/BRIEF.md
# FP/SIMD Issue Fault Gate

This block sits between instruction issue and the floating-point and packed-integer (SIMD) execution units. On every issued instruction it looks at the instruction class, whether SIMD execution exists on this core, the two control bits that flag a pending context switch (task-switched) and software emulation, and whether an unmasked floating-point exception is waiting to be reported. One cycle later it answers with exactly one of two strobes: a proceed strobe that allows the instruction to execute and write state, or a fault strobe with a 5-bit exception vector.

A faulting instruction never receives the proceed strobe, so it changes no register or tag state. The handler runs, and the same instruction is issued again from the start. The block also drives an error pin. A SIMD-group instruction that meets a pending floating-point error sets this pin, and the pin stays set until the clear input is pulsed.

Class encoding: 0 = FP, 1 = SIMD, 2 = clear-state (the SIMD state-release operation, part of the SIMD group), 3 = reserved.

Top module: `simd_issue_gate`

## Requirements
- R1: Results are registered. A proceed or fault appears in the cycle after `issueValid` is sampled high. With no issue, both strobes are low in the following cycle.
- R2: At most one of `proceed` and `fault` is high in any cycle. `faultVector` reads 0 whenever `fault` is low.
- R3: A SIMD-group instruction (class 1 or 2) faults with vector 6 when `simdSupported` is low. FP instructions (class 0) are not affected by `simdSupported`.
- R4: A SIMD-group instruction faults with vector 6 when `ctrlEm` is high, and it is never sent to emulation.
- R5: An FP instruction faults with vector 7 when `ctrlEm` is high.
- R6: When `ctrlTs` is high, both FP and SIMD-group instructions fault with vector 7.
- R7: A SIMD-group instruction faults with vector 16 when `fpErrPending` is high, and `errPin` rises with that fault. An FP instruction is not blocked by `fpErrPending`.
- R8: Once set, `errPin` stays high until `clearPending` is sampled high. If a new vector-16 fault occurs in the same cycle as the clear, the pin stays set.
- R9: Priority is vector 6, then vector 7, then vector 16. A lower-priority fault never sets `errPin`.
- R10: The reserved class 3 always faults with vector 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction is issued this cycle |
| issueClass | input | 2 | 0 FP, 1 SIMD, 2 clear-state, 3 reserved |
| simdSupported | input | 1 | SIMD execution exists |
| ctrlTs | input | 1 | Task-switched control bit |
| ctrlEm | input | 1 | Emulate control bit |
| fpErrPending | input | 1 | Unmasked FP exception waiting |
| clearPending | input | 1 | Pulse that clears `errPin` |
| proceed | output | 1 | Instruction may execute and commit |
| fault | output | 1 | Instruction faults, no state change |
| faultVector | output | 5 | Exception vector, 0 when no fault |
| errPin | output | 1 | Sticky external error indication |

## Verification
Each class is issued once with all control inputs clear, which shows that the clean path proceeds for FP, SIMD and clear-state. Each fault source is then raised alone on each class. These cases separate vector 6 (SIMD group only) from vector 7 (EM on FP, TS on both) and show that `simdSupported` and `fpErrPending` leave FP untouched. Combined conditions confirm the 6-over-7-over-16 priority and show that a masked vector-16 case does not set the error pin. The error pin is also checked across idle cycles, across a plain clear, and across a clear that coincides with a new vector-16 fault.

// File: rtl/simd_gate_pkg.sv
package simd_gate_pkg;
  localparam int VEC_W = 5;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_FP    = 2'd0,
    CLS_SIMD  = 2'd1,
    CLS_CLEAR = 2'd2,
    CLS_RSVD  = 2'd3
  } issue_cls_e;

  localparam logic [VEC_W-1:0] VEC_BAD_OP  = VEC_W'(6);
  localparam logic [VEC_W-1:0] VEC_NO_DEV  = VEC_W'(7);
  localparam logic [VEC_W-1:0] VEC_FP_ERR  = VEC_W'(16);

  // strobes from the decision logic to the output registers
  typedef struct packed {
    logic             doProceed;
    logic             doFault;
    logic             setErr;
    logic [VEC_W-1:0] vector;
  } gate_ctrl_t;
endpackage

// File: rtl/simd_gate_ctrl.sv
module simd_gate_ctrl
  import simd_gate_pkg::*;
(
  input  logic             issueValid,
  input  logic [CLS_W-1:0] issueClass,
  input  logic             simdSupported,
  input  logic             ctrlTs,
  input  logic             ctrlEm,
  input  logic             fpErrPending,
  output gate_ctrl_t       ctrl
);
  logic isFp, isSimdGrp, isRsvd;

  always_comb begin
    isFp      = (issueClass == CLS_FP);
    isSimdGrp = (issueClass == CLS_SIMD) || (issueClass == CLS_CLEAR);
    isRsvd    = (issueClass == CLS_RSVD);
  end

  // fixed priority: invalid opcode, then device not available, then FP error
  always_comb begin
    ctrl = '0;
    if (issueValid) begin
      if (isRsvd || (isSimdGrp && (!simdSupported || ctrlEm))) begin
        ctrl.doFault = 1'b1;
        ctrl.vector  = VEC_BAD_OP;
      end else if (ctrlTs || (isFp && ctrlEm)) begin
        ctrl.doFault = 1'b1;
        ctrl.vector  = VEC_NO_DEV;
      end else if (isSimdGrp && fpErrPending) begin
        ctrl.doFault = 1'b1;
        ctrl.setErr  = 1'b1;
        ctrl.vector  = VEC_FP_ERR;
      end else begin
        ctrl.doProceed = 1'b1;
      end
    end
  end
endmodule

// File: rtl/simd_gate_dp.sv
module simd_gate_dp
  import simd_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  gate_ctrl_t       ctrl,
  input  logic             clearPending,
  output logic             proceed,
  output logic             fault,
  output logic [VEC_W-1:0] faultVector,
  output logic             errPin
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      proceed     <= 1'b0;
      fault       <= 1'b0;
      faultVector <= '0;
      errPin      <= 1'b0;
    end else begin
      proceed     <= ctrl.doProceed;
      fault       <= ctrl.doFault;
      faultVector <= ctrl.doFault ? ctrl.vector : '0;
      if (ctrl.setErr)
        errPin <= 1'b1;
      else if (clearPending)
        errPin <= 1'b0;
    end
  end

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(proceed && fault));
  assert_vec_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !fault |-> faultVector == '0);
  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errPin && !clearPending) |=> errPin);
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errPin) |-> (fault && faultVector == VEC_FP_ERR));
endmodule

// File: rtl/simd_issue_gate.sv
module simd_issue_gate
  import simd_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [CLS_W-1:0] issueClass,
  input  logic             simdSupported,
  input  logic             ctrlTs,
  input  logic             ctrlEm,
  input  logic             fpErrPending,
  input  logic             clearPending,
  output logic             proceed,
  output logic             fault,
  output logic [VEC_W-1:0] faultVector,
  output logic             errPin
);
  gate_ctrl_t ctrl;

  simd_gate_ctrl u_ctrl (
    .issueValid    (issueValid),
    .issueClass    (issueClass),
    .simdSupported (simdSupported),
    .ctrlTs        (ctrlTs),
    .ctrlEm        (ctrlEm),
    .fpErrPending  (fpErrPending),
    .ctrl          (ctrl)
  );

  simd_gate_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .clearPending (clearPending),
    .proceed      (proceed),
    .fault        (fault),
    .faultVector  (faultVector),
    .errPin       (errPin)
  );

  assert_issue_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    (proceed || fault) |-> $past(issueValid));
  assert_em_simd_R4: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && ctrlEm && (issueClass == CLS_SIMD || issueClass == CLS_CLEAR))
      |=> (fault && faultVector == VEC_BAD_OP));
  assert_ts_R6: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && ctrlTs && issueClass == CLS_FP) |=> (fault && faultVector == VEC_NO_DEV));
  assert_rsvd_R10: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueClass == CLS_RSVD) |=> (fault && faultVector == VEC_BAD_OP));
endmodule

// File: tb/simd_issue_gate_tb.sv
module simd_issue_gate_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic issueValid = 1'b0, simdSupported = 1'b1, ctrlTs = 1'b0, ctrlEm = 1'b0;
  logic fpErrPending = 1'b0, clearPending = 1'b0;
  logic [1:0] issueClass = 2'd0;
  logic proceed, fault, errPin;
  logic [4:0] faultVector;
  int nTests = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_issue_gate u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueClass(issueClass),
    .simdSupported(simdSupported), .ctrlTs(ctrlTs), .ctrlEm(ctrlEm),
    .fpErrPending(fpErrPending), .clearPending(clearPending),
    .proceed(proceed), .fault(fault), .faultVector(faultVector), .errPin(errPin)
  );

  task automatic checkOut(string tag, logic eP, logic eF, int eV, logic eE);
    nTests++;
    if (proceed !== eP || fault !== eF || faultVector !== 5'(eV) || errPin !== eE) begin
      nFail++;
      $display("FAIL %s: got p=%0b f=%0b v=%0d e=%0b, expected p=%0b f=%0b v=%0d e=%0b",
               tag, proceed, fault, faultVector, errPin, eP, eF, eV, eE);
    end
  endtask

  // drive one issue at a falling edge, sample one cycle later at the next falling edge
  task automatic issueOne(logic [1:0] cls, logic sup, logic ts, logic em, logic pend,
                          logic clr, string tag, logic eP, logic eF, int eV, logic eE);
    @(negedge clk);
    issueValid = 1'b1; issueClass = cls; simdSupported = sup;
    ctrlTs = ts; ctrlEm = em; fpErrPending = pend; clearPending = clr;
    @(negedge clk);
    checkOut(tag, eP, eF, eV, eE);
    issueValid = 1'b0; ctrlTs = 1'b0; ctrlEm = 1'b0; fpErrPending = 1'b0;
    simdSupported = 1'b1; clearPending = 1'b0;
  endtask

  task automatic idleCycle(logic clr, string tag, logic eE);
    @(negedge clk);
    clearPending = clr;
    @(negedge clk);
    clearPending = 1'b0;
    checkOut(tag, 1'b0, 1'b0, 0, eE);
  endtask

  task automatic testClean();
    issueOne(2'd0, 1, 0, 0, 0, 0, "R1 FP clean proceeds", 1, 0, 0, 0);
    issueOne(2'd1, 1, 0, 0, 0, 0, "R1 SIMD clean proceeds", 1, 0, 0, 0);
    issueOne(2'd2, 1, 0, 0, 0, 0, "R1 clear-state proceeds", 1, 0, 0, 0);
    idleCycle(0, "R1 no issue no strobe", 0);
  endtask

  task automatic testInvalid();
    issueOne(2'd1, 0, 0, 0, 0, 0, "R3 SIMD unsupported", 0, 1, 6, 0);
    issueOne(2'd2, 0, 0, 0, 0, 0, "R3 clear unsupported", 0, 1, 6, 0);
    issueOne(2'd0, 0, 0, 0, 0, 0, "R3 FP ignores support", 1, 0, 0, 0);
    issueOne(2'd1, 1, 0, 1, 0, 0, "R4 SIMD EM", 0, 1, 6, 0);
    issueOne(2'd3, 1, 0, 0, 0, 0, "R10 reserved class", 0, 1, 6, 0);
  endtask

  task automatic testDevice();
    issueOne(2'd0, 1, 0, 1, 0, 0, "R5 FP EM", 0, 1, 7, 0);
    issueOne(2'd0, 1, 1, 0, 0, 0, "R6 FP TS", 0, 1, 7, 0);
    issueOne(2'd1, 1, 1, 0, 0, 0, "R6 SIMD TS", 0, 1, 7, 0);
  endtask

  task automatic testFpErr();
    issueOne(2'd0, 1, 0, 0, 1, 0, "R7 FP ignores pending", 1, 0, 0, 0);
    issueOne(2'd1, 1, 0, 0, 1, 0, "R7 SIMD pending error", 0, 1, 16, 1);
    idleCycle(0, "R8 pin held idle", 1);
    issueOne(2'd0, 1, 0, 0, 0, 0, "R8 pin held over proceed", 1, 0, 0, 1);
    idleCycle(1, "R8 pin cleared", 0);
    issueOne(2'd2, 1, 0, 0, 1, 0, "R7 clear-state pending", 0, 1, 16, 1);
    issueOne(2'd1, 1, 0, 0, 1, 1, "R8 set wins over clear", 0, 1, 16, 1);
    idleCycle(1, "R8 pin cleared again", 0);
  endtask

  task automatic testPriority();
    issueOne(2'd1, 1, 1, 1, 1, 0, "R9 EM over TS over pending", 0, 1, 6, 0);
    issueOne(2'd1, 0, 1, 0, 1, 0, "R9 unsupported over TS", 0, 1, 6, 0);
    issueOne(2'd1, 1, 1, 0, 1, 0, "R9 TS over pending, no pin", 0, 1, 7, 0);
    issueOne(2'd0, 1, 1, 1, 1, 0, "R9 FP EM+TS vector 7", 0, 1, 7, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1 reset state", 0, 0, 0, 0);
    rstN = 1'b1;
    testClean();
    testInvalid();
    testDevice();
    testFpErr();
    testPriority();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule